// File: doc/BRIEF.md
# PLCP Path Overhead Extractor with Data-Link Steering

This block sits behind a receive PLCP framer. For every received frame the framer hands it the twelve path overhead bytes one at a time, each with a 4-bit identity code, plus the parity the framer computed over the previous frame. The block serializes every overhead byte onto a one-bit overhead port with its own enable and a start-of-frame marker. On that port the parity byte is replaced by an error mask: received parity XOR computed parity, so a one bit marks a parity mismatch.

For the growth bytes, the user channel byte, the two management bytes and the low three bits of the status byte, the block keeps a debounced copy. A new value is stored only after it has arrived in three frames in a row. A one-cycle change flag marks each update. The status-byte field also has an unstable flag for the case where no value settles. A two-bit selector picks which bytes go to a downstream HDLC receiver as a byte-valid stream: the user channel byte, either management byte, or both management bytes joined into one link.

Identity codes: 0..5 = Z6..Z1, 6 = F1, 7 = B1 (parity), 8 = G1 (status), 9 = M2, 10 = M1, 11 = C1. Successive overhead bytes must arrive at least 8 clock cycles apart.

Top module: `plcpOhExtract`

## Requirements
- R1: A byte captured with `ohValid` high is sent on `serBit` MSB first. Its 8 bits appear in the 8 cycles after the capture edge, with `serEn` high for all 8. Bytes go out in arrival order, all twelve identities included.
- R2: `serSof` is high only during the first serialized bit of identity 0 (Z6), and never during any other bit.
- R3: For identity 7 the serialized byte is `ohByte ^ calcParity`. Every other identity is sent unchanged.
- R4: Each integrated field resets to 0. It takes a new value only when that value has arrived in 3 consecutive frames. A differing value in between restarts the count.
- R5: `changeFlags` bit f pulses for one cycle when field f's stored value changes. Re-accepting the value already stored gives no pulse. Field order: bits 0..5 = Z6..Z1, 6 = F1, 7 = M2, 8 = M1, 9 = G1 field. `accBytes[8f+7:8f]` holds field f for f = 0..8.
- R6: The G1 field is bits 2:0 of the G1 byte (its last three bits in MSB-first order) and is reported on `accG1`. The upper G1 bits have no effect on it.
- R7: `g1Unstable` sets when 8 consecutive G1 arrivals pass with no acceptance of the G1 field. It clears when a G1 field value is accepted.
- R8: `linkSel` picks the link source: 0 = F1, 1 = M2, 2 = M1, 3 = M2 and M1. A selected byte appears on `linkByte`, with `linkValid` high for one cycle, in the cycle after its capture edge. Unselected bytes give no `linkValid`.
- R9: With `linkSel` = 3, each frame delivers M2 then M1 as consecutive items of one stream.
- R10: During and right after reset, `serEn`, `serSof`, `linkValid`, `changeFlags`, `g1Unstable`, `accBytes` and `accG1` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ohValid | input | 1 | Overhead byte present this cycle |
| ohId | input | 4 | Identity code of the overhead byte |
| ohByte | input | 8 | Overhead byte value |
| calcParity | input | 8 | Parity computed by the framer, used at identity 7 |
| linkSel | input | 2 | HDLC link source select |
| serBit | output | 1 | Serial overhead data, MSB first |
| serEn | output | 1 | Serial bit valid |
| serSof | output | 1 | First bit of the frame's first overhead byte |
| accBytes | output | 72 | Debounced byte fields, 8 bits per field |
| accG1 | output | 3 | Debounced G1 field |
| changeFlags | output | 10 | One-cycle update pulses per field |
| g1Unstable | output | 1 | G1 field failed to settle |
| linkValid | output | 1 | Link byte valid |
| linkByte | output | 8 | Byte to HDLC receiver |

## Verification
The in-module assertions check several rules on every cycle. A change pulse always comes with a new stored value, and a stored value never moves without one. The start marker only ever appears with the serial enable. A new byte never overruns a serialization still in progress. The unstable flag rises only on a G1 arrival and falls only on an acceptance. Some properties need whole frame sequences that only the bench scenarios can show. These are the three-frame debounce and its restart, the silence on re-acceptance, the eight-frame unstable threshold, the exact serial bit order with the parity mask, and the ordering of the joined M2/M1 stream.

// File: rtl/plcpOhPkg.sv
package plcpOhPkg;
  localparam int ID_W        = 4;
  localparam int NUM_FIELDS  = 10;
  localparam int NUM_BYTE_F  = 9;
  localparam int G1_FIELD    = 9;
  localparam int G1_W        = 3;

  localparam logic [ID_W-1:0] ID_Z6 = 4'd0;
  localparam logic [ID_W-1:0] ID_F1 = 4'd6;
  localparam logic [ID_W-1:0] ID_B1 = 4'd7;
  localparam logic [ID_W-1:0] ID_G1 = 4'd8;
  localparam logic [ID_W-1:0] ID_M2 = 4'd9;
  localparam logic [ID_W-1:0] ID_M1 = 4'd10;

  typedef enum logic [1:0] {
    LINK_F1   = 2'd0,
    LINK_M2   = 2'd1,
    LINK_M1   = 2'd2,
    LINK_BOTH = 2'd3
  } linkSrc_e;

  typedef struct packed {
    logic                  load;
    logic                  sof;
    logic                  isB1;
    logic                  linkTake;
    logic [NUM_FIELDS-1:0] intEn;
  } ohStrobes_t;

  function automatic logic [ID_W-1:0] fieldToId(input int f);
    case (f)
      7:       fieldToId = ID_M2;
      8:       fieldToId = ID_M1;
      9:       fieldToId = ID_G1;
      default: fieldToId = ID_W'(f);
    endcase
  endfunction
endpackage

// File: rtl/plcpOhIntegrator.sv
module plcpOhIntegrator #(
  parameter int W        = 8,
  parameter int ACCEPT_N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc,
  output logic         change,
  output logic         acceptNow
);
  localparam int CW = $clog2(ACCEPT_N + 1);

  logic [W-1:0]  cand;
  logic [CW-1:0] runCnt;

  assign acceptNow = en && (din == cand) && (runCnt >= CW'(ACCEPT_N - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cand   <= '0;
      runCnt <= '0;
      acc    <= '0;
      change <= 1'b0;
    end else begin
      change <= 1'b0;
      if (en) begin
        if (din == cand) begin
          if (runCnt < CW'(ACCEPT_N)) runCnt <= runCnt + 1'b1;
        end else begin
          cand   <= din;
          runCnt <= CW'(1);
        end
        if (acceptNow && (acc != din)) begin
          acc    <= din;
          change <= 1'b1;
        end
      end
    end
  end

  // R5: a change pulse always comes with a new stored value
  a_r5_change_is_new: assert property (@(posedge clk) disable iff (!rstN)
    change |-> (acc != $past(acc)));
  // R4: the stored value never moves without a change pulse
  a_r4_hold_without_change: assert property (@(posedge clk) disable iff (!rstN)
    !change |-> $stable(acc));
endmodule

// File: rtl/plcpOhCtrl.sv
module plcpOhCtrl
  import plcpOhPkg::*;
#(
  parameter int UNSTABLE_N = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ohValid,
  input  logic [ID_W-1:0] ohId,
  input  logic [1:0]      linkSel,
  input  logic            g1Accept,
  output ohStrobes_t      strb,
  output logic            g1Unstable
);
  localparam int UW = $clog2(UNSTABLE_N + 1);

  logic [NUM_FIELDS-1:0] fieldEn;
  logic                  take;
  logic [UW-1:0]         missCnt;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fieldEn
    assign fieldEn[f] = ohValid && (ohId == fieldToId(f));
  end

  always_comb begin
    case (linkSrc_e'(linkSel))
      LINK_F1: take = (ohId == ID_F1);
      LINK_M2: take = (ohId == ID_M2);
      LINK_M1: take = (ohId == ID_M1);
      default: take = (ohId == ID_M2) || (ohId == ID_M1);
    endcase
    strb.load     = ohValid;
    strb.sof      = ohValid && (ohId == ID_Z6);
    strb.isB1     = (ohId == ID_B1);
    strb.linkTake = ohValid && take;
    strb.intEn    = fieldEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCnt    <= '0;
      g1Unstable <= 1'b0;
    end else if (fieldEn[G1_FIELD]) begin
      if (g1Accept) begin
        missCnt    <= '0;
        g1Unstable <= 1'b0;
      end else begin
        if (missCnt < UW'(UNSTABLE_N)) missCnt <= missCnt + 1'b1;
        if (missCnt == UW'(UNSTABLE_N - 1)) g1Unstable <= 1'b1;
      end
    end
  end

  // R7: unstable rises only on a G1 arrival, falls only on an acceptance
  a_r7_rise_on_g1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(g1Unstable) |-> $past(fieldEn[G1_FIELD]));
  a_r7_fall_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $fell(g1Unstable) |-> $past(g1Accept));
endmodule

// File: rtl/plcpOhDatapath.sv
module plcpOhDatapath
  import plcpOhPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ohStrobes_t   strb,
  input  logic [W-1:0] ohByte,
  input  logic [W-1:0] calcParity,
  output logic         serBit,
  output logic         serEn,
  output logic         serSof,
  output logic         linkValid,
  output logic [W-1:0] linkByte
);
  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  shReg;
  logic [BW-1:0] bitCnt;
  logic          sofPend;

  assign serEn  = (bitCnt != '0);
  assign serBit = serEn & shReg[W-1];
  assign serSof = sofPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      bitCnt    <= '0;
      sofPend   <= 1'b0;
      linkValid <= 1'b0;
      linkByte  <= '0;
    end else begin
      if (strb.load) begin
        shReg   <= strb.isB1 ? (ohByte ^ calcParity) : ohByte;
        bitCnt  <= BW'(W);
        sofPend <= strb.sof;
      end else if (serEn) begin
        shReg   <= shReg << 1;
        bitCnt  <= bitCnt - 1'b1;
        sofPend <= 1'b0;
      end
      linkValid <= strb.linkTake;
      if (strb.linkTake) linkByte <= ohByte;
    end
  end

  // R2: the start marker only appears with the enable
  a_r2_sof_with_enable: assert property (@(posedge clk) disable iff (!rstN)
    serSof |-> serEn);
  // R1: a new byte never overruns a serialization in progress
  a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (bitCnt <= BW'(1)));
  // R8: link output only follows a capture
  a_r8_link_after_take: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> $past(strb.load));
endmodule

// File: rtl/plcpOhExtract.sv
module plcpOhExtract
  import plcpOhPkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ACCEPT_N   = 3,
  parameter int UNSTABLE_N = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ohValid,
  input  logic [ID_W-1:0]              ohId,
  input  logic [BYTE_W-1:0]            ohByte,
  input  logic [BYTE_W-1:0]            calcParity,
  input  logic [1:0]                   linkSel,
  output logic                         serBit,
  output logic                         serEn,
  output logic                         serSof,
  output logic [NUM_BYTE_F*BYTE_W-1:0] accBytes,
  output logic [G1_W-1:0]              accG1,
  output logic [NUM_FIELDS-1:0]        changeFlags,
  output logic                         g1Unstable,
  output logic                         linkValid,
  output logic [BYTE_W-1:0]            linkByte
);
  ohStrobes_t            strb;
  logic [NUM_FIELDS-1:0] acceptVec;

  plcpOhCtrl #(.UNSTABLE_N(UNSTABLE_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .ohValid(ohValid), .ohId(ohId),
    .linkSel(linkSel), .g1Accept(acceptVec[G1_FIELD]),
    .strb(strb), .g1Unstable(g1Unstable)
  );

  plcpOhDatapath #(.W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ohByte(ohByte),
    .calcParity(calcParity), .serBit(serBit), .serEn(serEn),
    .serSof(serSof), .linkValid(linkValid), .linkByte(linkByte)
  );

  for (genvar f = 0; f < NUM_BYTE_F; f++) begin : g_byteField
    plcpOhIntegrator #(.W(BYTE_W), .ACCEPT_N(ACCEPT_N)) integ_i (
      .clk(clk), .rstN(rstN), .en(strb.intEn[f]), .din(ohByte),
      .acc(accBytes[f*BYTE_W +: BYTE_W]), .change(changeFlags[f]),
      .acceptNow(acceptVec[f])
    );
  end

  plcpOhIntegrator #(.W(G1_W), .ACCEPT_N(ACCEPT_N)) g1Integ_i (
    .clk(clk), .rstN(rstN), .en(strb.intEn[G1_FIELD]),
    .din(ohByte[G1_W-1:0]), .acc(accG1), .change(changeFlags[G1_FIELD]),
    .acceptNow(acceptVec[G1_FIELD])
  );
endmodule

// File: tb/plcpOhExtract_tb_top.sv
module plcpOhExtract_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ohValid = 1'b0;
  logic [3:0]  ohId = '0;
  logic [7:0]  ohByte = '0;
  logic [7:0]  calcParity = '0;
  logic [1:0]  linkSel = '0;
  logic        serBit, serEn, serSof, g1Unstable, linkValid;
  logic [71:0] accBytes;
  logic [2:0]  accG1;
  logic [9:0]  changeFlags;
  logic [7:0]  linkByte;

  int errors = 0;
  int checks = 0;
  int chgCnt [10];
  logic [12:0] serQ [$];
  logic [7:0]  linkQ [$];
  int curSel = 0;

  always #2 clk = ~clk;

  plcpOhExtract dut_i (
    .clk(clk), .rstN(rstN), .ohValid(ohValid), .ohId(ohId), .ohByte(ohByte),
    .calcParity(calcParity), .linkSel(linkSel), .serBit(serBit), .serEn(serEn),
    .serSof(serSof), .accBytes(accBytes), .accG1(accG1),
    .changeFlags(changeFlags), .g1Unstable(g1Unstable),
    .linkValid(linkValid), .linkByte(linkByte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [3:0] id, input logic [7:0] b, input logic [7:0] par);
    @(negedge clk);
    ohValid = 1'b1; ohId = id; ohByte = b; calcParity = par;
    serQ.push_back({id, (id == 4'd0), (id == 4'd7) ? (b ^ par) : b});
    if ((curSel == 0 && id == 4'd6) || ((curSel == 1 || curSel == 3) && id == 4'd9) ||
        ((curSel == 2 || curSel == 3) && id == 4'd10))
      linkQ.push_back(b);
    @(negedge clk);
    ohValid = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] f1, input logic [7:0] g1,
                           input logic [7:0] m2, input logic [7:0] m1);
    for (int i = 0; i < 12; i++) begin
      case (i)
        6:       sendByte(4'(i), f1, 8'h3C);
        7:       sendByte(4'(i), 8'hC3, 8'h0F);
        8:       sendByte(4'(i), g1, 8'h3C);
        9:       sendByte(4'(i), m2, 8'h3C);
        10:      sendByte(4'(i), m1, 8'h3C);
        11:      sendByte(4'(i), 8'hE7, 8'h3C);
        default: sendByte(4'(i), 8'h10 + 8'(i), 8'h3C);
      endcase
    end
  endtask

  // monitors: serial scoreboard, link scoreboard, change pulse counters
  int bitIdx = 0;
  logic firstSof = 1'b0;
  logic [7:0] collect = '0;
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 10; i++) if (changeFlags[i]) chgCnt[i]++;
      if (serEn) begin
        if (bitIdx == 0) firstSof = serSof;
        else if (serSof) chk("R2 sof on later bit", 1, 0);
        collect = {collect[6:0], serBit};
        bitIdx++;
        if (bitIdx == 8) begin
          bitIdx = 0;
          if (serQ.size() == 0) chk("R1 unexpected serial byte", 1, 0);
          else begin
            logic [12:0] e;
            e = serQ.pop_front();
            chk((e[12:9] == 4'd7) ? "R3 parity mask" : "R1 serial byte", 32'(collect), 32'(e[7:0]));
            chk("R2 sof marker", 32'(firstSof), 32'(e[8]));
          end
        end
      end else if (bitIdx != 0) begin
        chk("R1 enable dropped mid-byte", 1, 0);
        bitIdx = 0;
      end
      if (linkValid) begin
        if (linkQ.size() == 0) chk("R8 unexpected link byte", 32'(linkByte), 32'hFFFF);
        else chk("R8/R9 link byte", 32'(linkByte), 32'(linkQ.pop_front()));
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) chgCnt[i] = 0;
    repeat (4) @(negedge clk);
    chk("R10 serEn in reset", 32'(serEn), 0);
    chk("R10 linkValid in reset", 32'(linkValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 serEn", 32'(serEn), 0);
    chk("R10 serSof", 32'(serSof), 0);
    chk("R10 accBytes", 32'(accBytes != '0), 0);
    chk("R10 accG1", 32'(accG1), 0);
    chk("R10 changeFlags", 32'(changeFlags), 0);
    chk("R10 unstable", 32'(g1Unstable), 0);

    curSel = 0; linkSel = 2'd0;
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    chk("R4 F1 not yet accepted", 32'(accBytes[55:48]), 0);
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    chk("R4 F1 accepted", 32'(accBytes[55:48]), 32'h5A);
    chk("R4 Z6 accepted", 32'(accBytes[7:0]), 32'h10);
    chk("R4 M1 accepted", 32'(accBytes[71:64]), 32'h22);
    chk("R5 F1 one pulse", chgCnt[6], 1);
    chk("R5 Z1 one pulse", chgCnt[5], 1);
    chk("R5 G1 no pulse for 0", chgCnt[9], 0);

    sendFrame(8'h33, 8'h00, 8'h21, 8'h22);
    sendFrame(8'h33, 8'h00, 8'h21, 8'h22);
    chk("R4 interrupted run held", 32'(accBytes[55:48]), 32'h5A);
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    chk("R5 re-accept same, no pulse", chgCnt[6], 1);
    chk("R4 value kept", 32'(accBytes[55:48]), 32'h5A);

    curSel = 3; linkSel = 2'd3;
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    curSel = 1; linkSel = 2'd1;
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);
    curSel = 2; linkSel = 2'd2;
    sendFrame(8'h5A, 8'h00, 8'h21, 8'h22);

    curSel = 0; linkSel = 2'd0;
    for (int k = 0; k < 3; k++) sendFrame(8'h77, 8'h00, 8'h21, 8'h22);
    chk("R4 F1 new value", 32'(accBytes[55:48]), 32'h77);
    chk("R5 F1 second pulse", chgCnt[6], 2);

    for (int k = 0; k < 7; k++) sendFrame(8'h77, (k % 2 == 0) ? 8'hF1 : 8'hF2, 8'h21, 8'h22);
    chk("R7 unstable not after 7", 32'(g1Unstable), 0);
    sendFrame(8'h77, 8'hF2, 8'h21, 8'h22);
    chk("R7 unstable after 8", 32'(g1Unstable), 1);
    chk("R6 G1 held", 32'(accG1), 0);
    sendFrame(8'h77, 8'hA5, 8'h21, 8'h22);
    sendFrame(8'h77, 8'hA5, 8'h21, 8'h22);
    chk("R7 still unstable", 32'(g1Unstable), 1);
    sendFrame(8'h77, 8'hA5, 8'h21, 8'h22);
    chk("R7 cleared on accept", 32'(g1Unstable), 0);
    chk("R6 G1 low bits", 32'(accG1), 5);
    chk("R5 G1 pulse", chgCnt[9], 1);

    repeat (20) @(negedge clk);
    chk("R1 serial queue drained", serQ.size(), 0);
    chk("R8 link queue drained", linkQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule